// File: doc/BRIEF.md
# Ripple-Block Lookahead Adder

This block is a purely combinational two-operand binary adder. It takes two N-bit operands and a carry-in and returns an N-bit sum and a carry-out. The operands are split into 4-bit slices. Each slice forms the carries for its own bit positions with flat lookahead logic, built from per-bit generate and propagate terms. It also exports a slice-level generate/propagate pair.

Slice carries then travel between slices in one of two ways, chosen by width at elaboration:

- **Fewer than five slices:** the carry leaving each slice feeds the next slice directly, in a chain.
- **Five or more slices:** the slices are gathered four to a group. A second lookahead unit of the same shape computes every slice carry inside a group from the slice pairs. The groups then pass their carries along in a chain. A group that is not full is padded with neutral (generate 0, propagate 1) entries, so its outgoing carry stays exact.

The adder is meant as a drop-in combinational datapath element. Its outputs are valid once its inputs settle, and it holds no state.

Top module: `rbcla_adder`

## Requirements
- R1: For every operand value, {cout, sum} equals the arithmetic value a + b + cin, with cout as bit N.
- R2: When a and b differ in every bit position and cin is 1, sum is all zeros and cout is 1, because the carry crosses every slice.
- R3: With a = b = all ones and cin = 0, sum is all ones except bit 0, which is 0, and cout is 1. With a = b = 0 and cin = 0, sum and cout are 0.
- R4: A carry generated only at the top bit of slice k (a = b = 1 << (4k+3), cin = 0) sets exactly sum bit 4k+4. For the top slice it sets cout instead, and sum is zero.
- R5: At widths below five slices (8 and 16 bits), where slice carries are chained, the result obeys R1.
- R6: At widths of five or more slices (20 and 32 bits), including a partly filled last group (20 bits: one slice in the second group), the result obeys R1.
- R7: The carry entering slice k equals the carry out of bit 4k-1 of the sum of the low 4k operand bits plus cin. With a = 2^(4k) - 1, b = 0 and cin = 1, sum is exactly 1 << 4k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits, each being the bit propagate XOR the carry into that bit |
| cout | output | 1 | Carry leaving the top slice |

## Verification
The bench builds four copies of the adder, at 8, 16, 20 and 32 bits, so that both carry-passing variants are covered on each side of the five-slice threshold.

- **8 bits:** two chained slices, small enough to sweep every operand pair with both carry-in values.
- **16 bits:** the widest chained form.
- **20 bits:** just reaches the grouped form and leaves a group with a single real slice, which exercises the neutral padding.
- **32 bits:** two full groups. This copy receives the directed patterns on slice boundaries, full carry chains and all-generate operands, plus random vectors.

// File: rtl/rbcla_pkg.sv
package rbcla_pkg;

    // Fixed slice width and group fan-in of the second lookahead tier.
    localparam int BLK_W      = 4;
    localparam int GRP_BLKS   = 4;
    // Slice count at which the second lookahead tier is used.
    localparam int TIER2_MIN  = 5;

    // Generate / propagate pair carried through the datapath.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Neutral element of the carry operator, used to pad a partial group.
    localparam gp_t GP_NEUTRAL = '{g: 1'b0, p: 1'b1};

    // Carry operator: combine a more significant pair with a less significant one.
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Carry leaving a span described by grp, given the carry entering it.
    function automatic logic gp_carry(gp_t grp, logic c_in);
        return grp.g | (grp.p & c_in);
    endfunction

endpackage

// File: rtl/rbcla_bitgp.sv
module rbcla_bitgp
    import rbcla_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output gp_t  [W-1:0]    bit_gp
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_gp[i].g = a[i] & b[i];
        assign bit_gp[i].p = a[i] ^ b[i];
    end

endmodule

// File: rtl/rbcla_lookahead4.sv
module rbcla_lookahead4
    import rbcla_pkg::*;
(
    input  gp_t  [3:0]  gp_in,
    input  logic        c_in,
    output logic [3:0]  c_vec,
    output gp_t         grp
);

    logic [3:0] g;
    logic [3:0] p;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            g[i] = gp_in[i].g;
            p[i] = gp_in[i].p;
        end
    end

    // Flat two-level lookahead: every carry is a sum of products of the inputs.
    assign c_vec[0] = c_in;
    assign c_vec[1] = g[0] | (p[0] & c_in);
    assign c_vec[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_in);
    assign c_vec[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                    | (p[2] & p[1] & p[0] & c_in);

    assign grp.g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                 | (p[3] & p[2] & p[1] & g[0]);
    assign grp.p = &p;

endmodule

// File: rtl/rbcla_adder.sv
module rbcla_adder
    import rbcla_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    localparam int  NBLK     = N / BLK_W;
    localparam bit  USE_T2   = (NBLK >= TIER2_MIN);
    localparam int  NGRP     = (NBLK + GRP_BLKS - 1) / GRP_BLKS;
    localparam int  NBLK_PAD = NGRP * GRP_BLKS;

    if (((N % BLK_W) != 0) || (N < BLK_W)) begin : g_bad_width
        $error("rbcla_adder: N must be a positive multiple of 4");
    end

    gp_t  [N-1:0]    bit_gp;
    logic [N-1:0]    bit_c;
    gp_t  [NBLK-1:0] blk_gp;
    logic [NBLK:0]   blk_c;

    rbcla_bitgp #(.W(N)) u_bitgp (
        .a      (a),
        .b      (b),
        .bit_gp (bit_gp)
    );

    // First tier: one lookahead unit per 4-bit slice.
    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        rbcla_lookahead4 u_blk (
            .gp_in (bit_gp[BLK_W*k +: BLK_W]),
            .c_in  (blk_c[k]),
            .c_vec (bit_c[BLK_W*k +: BLK_W]),
            .grp   (blk_gp[k])
        );
    end

    assign blk_c[0] = cin;

    if (!USE_T2) begin : g_chain
        // Slice carries pass from one slice to the next.
        for (genvar k = 0; k < NBLK; k++) begin : g_link
            assign blk_c[k+1] = gp_carry(blk_gp[k], blk_c[k]);
        end
    end else begin : g_tier2
        gp_t  [NBLK_PAD-1:0] pad_gp;
        logic [NBLK_PAD-1:0] pad_c;
        gp_t  [NGRP-1:0]     grp_gp;
        logic [NGRP:0]       grp_c;

        for (genvar j = 0; j < NBLK_PAD; j++) begin : g_pad
            if (j < NBLK) begin : g_real
                assign pad_gp[j] = blk_gp[j];
            end else begin : g_fill
                assign pad_gp[j] = GP_NEUTRAL;
            end
        end

        assign grp_c[0] = cin;

        // Second tier: lookahead over slice pairs, groups chained.
        for (genvar s = 0; s < NGRP; s++) begin : g_grp
            rbcla_lookahead4 u_grp (
                .gp_in (pad_gp[GRP_BLKS*s +: GRP_BLKS]),
                .c_in  (grp_c[s]),
                .c_vec (pad_c[GRP_BLKS*s +: GRP_BLKS]),
                .grp   (grp_gp[s])
            );
            assign grp_c[s+1] = gp_carry(grp_gp[s], grp_c[s]);
        end

        for (genvar k = 1; k < NBLK; k++) begin : g_take
            assign blk_c[k] = pad_c[k];
        end
        assign blk_c[NBLK] = grp_c[NGRP];
    end

    for (genvar i = 0; i < N; i++) begin : g_sum
        assign sum[i] = bit_gp[i].p ^ bit_c[i];
    end

    assign cout = blk_c[NBLK];

endmodule

// File: rtl/rbcla_adder_chk.sv
module rbcla_adder_chk #(
    parameter int N    = 32,
    parameter int NBLK = N / 4
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         cin,
    input logic [N-1:0] sum,
    input logic         cout,
    input logic [NBLK:0] blk_c
);

    always_comb begin
        logic [N:0] mask;
        logic [N:0] low;
        assert_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (N+1)'(cin)))
            else $error("R1 sum mismatch");
        if (((a ^ b) == {N{1'b1}}) && cin) begin
            assert_full_chain_R2: assert ((sum == '0) && cout)
                else $error("R2 chain mismatch");
        end
        if ((a == {N{1'b1}}) && (b == {N{1'b1}})) begin
            assert_all_gen_R3: assert (cout)
                else $error("R3 carry-out missing");
        end
        for (int k = 0; k <= NBLK; k++) begin
            mask = ((N+1)'(1) << (4 * k)) - (N+1)'(1);
            low  = ({1'b0, a} & mask) + ({1'b0, b} & mask) + (N+1)'(cin);
            assert_blk_carry_R7: assert (blk_c[k] == low[4 * k])
                else $error("R7 slice carry mismatch");
        end
    end

endmodule

bind rbcla_adder rbcla_adder_chk #(.N(N)) u_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .blk_c (blk_c)
);

// File: tb/rbcla_adder_tb.sv
module rbcla_adder_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] a32, b32, s32;  logic c32, co32;
    logic [19:0] a20, b20, s20;  logic c20, co20;
    logic [15:0] a16, b16, s16;  logic c16, co16;
    logic [7:0]  a8,  b8,  s8;   logic c8,  co8;

    rbcla_adder #(.N(32)) u_dut   (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
    rbcla_adder #(.N(20)) u_dut20 (.a(a20), .b(b20), .cin(c20), .sum(s20), .cout(co20));
    rbcla_adder #(.N(16)) u_dut16 (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
    rbcla_adder #(.N(8))  u_dut8  (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));

    task automatic chk(string tag, logic [32:0] got, logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive32(logic [31:0] x, logic [31:0] y, logic ci);
        a32 = x; b32 = y; c32 = ci;
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        a32 = '0; b32 = '0; c32 = 1'b0;
        a20 = '0; b20 = '0; c20 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3: zero operands during reset give a zero result
        chk("R3", {co32, s32}, 33'h0);
        rst = 1'b0;

        // R3: all-generate operands
        drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        chk("R3", {co32, s32}, 33'h1_FFFF_FFFE);

        // R2: full propagate chain, several patterns
        drive32(32'hFFFF_FFFF, 32'h0, 1'b1);
        chk("R2", {co32, s32}, 33'h1_0000_0000);
        drive32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        chk("R2", {co32, s32}, 33'h1_0000_0000);
        drive32(32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b1);
        chk("R2", {co32, s32}, 33'h1_0000_0000);
        a20 = 20'hFFFFF; b20 = 20'h0; c20 = 1'b1; #1;
        chk("R2", {13'h0, co20, s20}, 33'h0_0010_0000);

        // R4: carry generated at the top bit of each slice
        for (int k = 0; k < 8; k++) begin
            drive32(32'h1 << (4*k+3), 32'h1 << (4*k+3), 1'b0);
            if (k == 7) chk("R4", {co32, s32}, 33'h1_0000_0000);
            else        chk("R4", {co32, s32}, 33'h1 << (4*k+4));
        end

        // R7: carry entering each slice from the low bits and cin
        for (int k = 0; k <= 8; k++) begin
            logic [32:0] lowones;
            lowones = (33'h1 << (4*k)) - 33'h1;
            drive32(lowones[31:0], 32'h0, 1'b1);
            chk("R7", {co32, s32}, 33'h1 << (4*k));
            drive32(lowones[31:0], 32'h0, 1'b0);
            chk("R7", {co32, s32}, lowones);
        end

        // R1: random vectors at 32 bits
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] x, y; logic ci;
            x = $urandom(); y = $urandom(); ci = 1'($urandom());
            drive32(x, y, ci);
            chk("R1", {co32, s32}, {1'b0, x} + {1'b0, y} + 33'(ci));
        end

        // R6: five slices, partly filled last group
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] x, y; logic ci;
            x = 20'($urandom()); y = 20'($urandom()); ci = 1'($urandom());
            a20 = x; b20 = y; c20 = ci; #1;
            chk("R6", {13'h0, co20, s20}, 33'({1'b0, x} + {1'b0, y} + 21'(ci)));
        end
        for (int k = 0; k < 5; k++) begin
            a20 = 20'h1 << (4*k+3); b20 = 20'h1 << (4*k+3); c20 = 1'b0; #1;
            chk("R6", {13'h0, co20, s20}, 33'h1 << (4*k+4));
        end

        // R5: chained slices at 16 bits
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] x, y; logic ci;
            x = 16'($urandom()); y = 16'($urandom()); ci = 1'($urandom());
            a16 = x; b16 = y; c16 = ci; #1;
            chk("R5", {16'h0, co16, s16}, 33'({1'b0, x} + {1'b0, y} + 17'(ci)));
        end

        // R5: exhaustive sweep at 8 bits
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    a8 = 8'(x); b8 = 8'(y); c8 = 1'(ci); #1;
                    chk("R5", {24'h0, co8, s8}, 33'(x + y + ci));
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule